// File: doc/BRIEF.md
# Condition Code Flag Unit

This block derives the negative, zero, overflow and carry flags from an ALU operation and keeps them in an 8-bit condition-code register. The datapath computes the result. This unit receives both operands, the result, an operation class, a width select and the bit shifted out by a shift. When the update strobe is high, the register takes the new flags on the rising clock edge. Flags that the operation does not define keep their old value.

Carry and overflow come only from the most significant bits of the two operands and the result, so no second adder is needed. The width select picks bit 7 or bit 15 as the sign bit and sets how much of the result is compared against zero. The upper nibble holds the half-carry and mask bits. This unit never writes that nibble, so it keeps its reset value.

Top module: `ccr_flag_unit`

## Requirements
- R1: While reset is asserted (active low, asynchronous), the register reads 0xD0. Bit layout: C=0, V=1, Z=2, N=3, I=4, H=5, X=6, S=7.
- R2: When the update strobe is low, all eight bits keep their value across the clock edge, whatever the other inputs are.
- R3: For an add (op code 0), C becomes the sign bit of (a&b)|(b&~r)|(a&~r).
- R4: For an add, V becomes the sign bit of (a&b&~r)|(~a&~b&r).
- R5: For a subtract (op code 1), C becomes the sign bit of (~a&b)|(b&r)|(~a&r).
- R6: For a subtract, V becomes the sign bit of (a&~b&~r)|(~a&b&r).
- R7: For an add or a subtract, N becomes the sign bit of r, and Z becomes 1 exactly when r is zero at the selected width.
- R8: For a test (op code 2), V is cleared, N and Z follow r, and C keeps its previous value.
- R9: For a shift (op code 3), N and Z follow r, C takes the shifted-out input, and V becomes the new N xor the new C.
- R10: With the width select at 0, the sign bit is bit 7 and only r[7:0] is tested for zero; bits 15:8 of a, b and r have no effect. With the width select at 1, the sign bit is bit 15 and all 16 bits of r are tested.
- R11: After reset, bits 7:4 of the register keep the value 0xD.
- R12: The four single-flag outputs always equal bits 0 to 3 of the register output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Update strobe |
| op_i | input | 2 | Operation class: 0 add, 1 subtract, 2 test, 3 shift |
| wide_i | input | 1 | 0 selects 8-bit, 1 selects 16-bit |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| r_i | input | 16 | ALU result |
| shc_i | input | 1 | Bit shifted out by a shift |
| ccr_o | output | 8 | Condition-code register |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |

## Verification
Every flag comes from one register. A strobe sampled at a rising edge therefore shows on the outputs right after that edge. Nothing depends on the same-cycle inputs. The bench drives each stimulus on a falling edge and removes the strobe at the next falling edge. It compares all outputs at that point, exactly one rising edge after the drive. The hold check applies a stimulus with the strobe low and reads the outputs one edge later, where an unwanted write would already be visible.

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit #(
  parameter int W = 16,
  parameter int NW = 8,
  parameter logic [7:0] RST_VAL = 8'hD0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_i,
  input  logic [1:0]   op_i,
  input  logic         wide_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] r_i,
  input  logic         shc_i,
  output logic [7:0]   ccr_o,
  output logic         c_o,
  output logic         v_o,
  output logic         z_o,
  output logic         n_o
);
  localparam logic [1:0] OP_ADD = 2'd0, OP_SUB = 2'd1, OP_TST = 2'd2, OP_SHF = 2'd3;

  logic [7:0] ccr_q;
  logic       am, bm, rm, zr;
  logic       add_c, add_v, sub_c, sub_v;
  logic       nc, nv;

  assign am = wide_i ? a_i[W-1] : a_i[NW-1];
  assign bm = wide_i ? b_i[W-1] : b_i[NW-1];
  assign rm = wide_i ? r_i[W-1] : r_i[NW-1];
  assign zr = wide_i ? (r_i == '0) : (r_i[NW-1:0] == '0);

  assign add_c = (am & bm) | (bm & ~rm) | (am & ~rm);
  assign add_v = (am & bm & ~rm) | (~am & ~bm & rm);
  assign sub_c = (~am & bm) | (bm & rm) | (~am & rm);
  assign sub_v = (am & ~bm & ~rm) | (~am & bm & rm);

  always_comb begin
    nc = ccr_q[0];
    nv = 1'b0;
    case (op_i)
      OP_ADD: begin nc = add_c; nv = add_v; end
      OP_SUB: begin nc = sub_c; nv = sub_v; end
      OP_TST: begin nc = ccr_q[0]; nv = 1'b0; end
      OP_SHF: begin nc = shc_i; nv = rm ^ shc_i; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ccr_q <= RST_VAL;
    else if (upd_i) ccr_q <= {ccr_q[7:4], rm, zr, nv, nc};
  end

  assign ccr_o = ccr_q;
  assign c_o = ccr_q[0];
  assign v_o = ccr_q[1];
  assign z_o = ccr_q[2];
  assign n_o = ccr_q[3];
endmodule

module ccr_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_i,
  input logic [1:0] op_i,
  input logic       shc_i,
  input logic [7:0] ccr_o,
  input logic       c_o,
  input logic       v_o,
  input logic       n_o
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(ccr_o));
  assert_upper_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_o[7:4] == 4'hD);
  assert_test_v_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && op_i == 2'd2) |=> !v_o);
  assert_test_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && op_i == 2'd2) |=> c_o == $past(c_o));
  assert_shift_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && op_i == 2'd3) |=> c_o == $past(shc_i));
  assert_shift_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && op_i == 2'd3) |=> v_o == (n_o ^ c_o));
endmodule

bind ccr_flag_unit ccr_flag_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .op_i(op_i), .shc_i(shc_i),
  .ccr_o(ccr_o), .c_o(c_o), .v_o(v_o), .n_o(n_o)
);

// File: tb/ccr_flag_unit_bench.sv
module ccr_flag_unit_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 13;
  // {op[55:54], wide[53], shc[52], a[51:36], b[35:20], r[19:4], nzvc[3:0]}
  localparam logic [55:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 4'hA}, // R4 R7 add overflow
    {2'd0, 1'b0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 4'h5}, // R3 R7 add carry, zero
    {2'd1, 1'b0, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 4'h9}, // R5 sub borrow
    {2'd2, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h8000, 4'h9}, // R8 test keeps C=1
    {2'd1, 1'b0, 1'b0, 16'h0080, 16'h0001, 16'h007F, 4'h2}, // R6 sub overflow
    {2'd2, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0100, 4'h4}, // R8 R10 8-bit zero
    {2'd0, 1'b1, 1'b0, 16'h8000, 16'h8000, 16'h0000, 4'h7}, // R3 R4 16-bit add
    {2'd1, 1'b1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 4'h9}, // R5 16-bit sub
    {2'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0080, 4'hA}, // R9 N=1 C=0
    {2'd3, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 4'h7}, // R9 Z, C=1
    {2'd3, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h8000, 4'h9}, // R9 N=C=1, V=0
    {2'd0, 1'b0, 1'b0, 16'h12FF, 16'h3401, 16'hAB00, 4'h5}, // R10 upper ignored
    {2'd0, 1'b1, 1'b0, 16'h00FF, 16'h0001, 16'h0100, 4'h0}  // R10 bit 15 is sign
  };

  logic clk = 1'b0, rst_n = 1'b0, upd_i = 1'b0, wide_i = 1'b0, shc_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [15:0] a_i = '0, b_i = '0, r_i = '0;
  logic [7:0] ccr_o;
  logic c_o, v_o, z_o, n_o;
  int n_cmp = 0, n_bad = 0;

  ccr_flag_unit u_ccr_flag_unit (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .op_i(op_i), .wide_i(wide_i),
    .a_i(a_i), .b_i(b_i), .r_i(r_i), .shc_i(shc_i),
    .ccr_o(ccr_o), .c_o(c_o), .v_o(v_o), .z_o(z_o), .n_o(n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [55:0] v, input logic strobe);
    @(negedge clk);
    op_i = v[55:54]; wide_i = v[53]; shc_i = v[52];
    a_i = v[51:36]; b_i = v[35:20]; r_i = v[19:4];
    upd_i = strobe;
    @(negedge clk);
    upd_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    check8("R1 reset value", ccr_o, 8'hD0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check8("R1 after release", ccr_o, 8'hD0);
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i], 1'b1);
      check8($sformatf("R3-R10 vector %0d (R11 upper nibble)", i), ccr_o, {4'hD, VEC[i][3:0]});
      check8("R12 flag outputs", {4'h0, n_o, z_o, v_o, c_o}, {4'h0, ccr_o[3:0]});
    end
    // R2: strobe low, stimulus that would set N,V (add 7F+01=80)
    apply(VEC[0], 1'b0);
    check8("R2 hold without strobe", ccr_o, 8'hD0);
    apply(VEC[2], 1'b0);
    check8("R2 hold sub without strobe", ccr_o, 8'hD0);
    // R8: test with C=1 held from prior add
    apply(VEC[1], 1'b1);
    apply({2'd2, 1'b0, 1'b0, 16'h0, 16'h0, 16'h00F0, 4'h0}, 1'b1);
    check8("R8 test keeps C", ccr_o, 8'hD9);
    // R1: asynchronous reset mid-run
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #(CLK_PERIOD/4);
    check8("R1 async reset", ccr_o, 8'hD0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule